// File: doc/BRIEF.md
# Add/Subtract Unit with Flags

This block is the arithmetic half of a small processor's execution stage. It takes two operands, A and T, and either adds T to A or subtracts T from A. Subtraction is done the two's-complement way: each bit of T is inverted by an XOR with the mode bit before it reaches a plain ripple adder. The carry into bit 0 is a separate input. A caller can therefore do an isolated add (carry-in 0), an isolated subtract (mode 1, carry-in 1), or chain the carry-out of one byte into the next byte for add-with-carry and subtract-with-borrow across wider words.

Besides the sum, the unit produces four condition flags: zero, negative, carry and signed overflow. The overflow flag is based on the operand that actually enters the adder, which is T after the conditional inversion. This keeps the flag correct for subtraction. The block is purely combinational and has no clock or reset. Latching the flags, storing operands and decoding instructions are left to the surrounding datapath.

Top module: `addsub_flags`

## Requirements
- R1: With `sub_sel` = 0, `sum` equals (A + T + `cin`) modulo 2^WIDTH (WIDTH = 8 by default).
- R2: With `sub_sel` = 1, `sum` equals (A + ~T + `cin`) modulo 2^WIDTH, so `sub_sel` = 1 with `cin` = 1 gives A − T.
- R3: `flag_c` equals bit WIDTH (the carry-out) of the WIDTH+1-bit sum of A, the effective T and `cin`.
- R4: `flag_n` equals the most significant bit of `sum`.
- R5: `flag_z` is 1 only when every bit of `sum` is 0.
- R6: `flag_v` is 1 when A and the effective T (T XOR `sub_sel`) have the same sign bit and `sum` has a different sign bit. This matches the case where the signed result falls outside the signed WIDTH-bit range.
- R7: With `sub_sel` = 1 and `cin` = 1, `flag_c` = 1 exactly when A ≥ T as unsigned numbers (1 means no borrow).
- R8: Feeding the low byte's `flag_c` into the high byte's `cin` gives correct 16-bit increment (add 1 with carry) and decrement (subtract 1 with borrow) results, including across the 0x00FF/0x0100 boundary and the wrap at 0xFFFF/0x0000.
- R9: The unit has no storage. Every output reflects the current inputs without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | Operand A, fed to the adder unchanged |
| opb | input | WIDTH | Operand T, inverted when subtracting |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| cin | input | 1 | Carry into bit 0, independent of the mode |
| sum | output | WIDTH | Result |
| flag_z | output | 1 | Result is all zeros |
| flag_n | output | 1 | Result sign bit |
| flag_c | output | 1 | Carry-out of the top bit |
| flag_v | output | 1 | Signed overflow |

## Verification
The bench targets four corners:
- 0x7F + 1 should raise overflow and negative. A design that took overflow from the carry alone would leave the overflow flag low here.
- 0x80 − 1 should give 0x7F with overflow set. If overflow were computed from the raw T rather than the inverted T, the flag would be wrong in this case.
- 0xFF + 1 and 0 − 0 should both give zero with carry set. A design that inverted the carry for subtraction would clear it for 0 − 0, and a broken zero detector would miss both cases.
- Chained 16-bit increments and decrements across byte boundaries expose a carry-in that is ignored or tied to the mode bit.

Random operands in all four mode/carry combinations are then checked against a reference computed at 9-bit unsigned and signed integer width.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned DEF_WIDTH = 8;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } cond_flags_t;
endpackage

// File: rtl/addsub_operand_cond.sv
module addsub_operand_cond #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] raw_b,
  input  logic             invert,
  output logic [WIDTH-1:0] eff_b
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_xor
      assign eff_b[i] = raw_b[i] ^ invert;
    end
  endgenerate
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic [WIDTH:0] chain;

  assign chain[0] = carry_in;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_fa
      logic half;
      assign half        = in_a[i] ^ in_b[i];
      assign result[i]   = half ^ chain[i];
      assign chain[i+1]  = (in_a[i] & in_b[i]) | (half & chain[i]);
    end
  endgenerate

  assign carry_out = chain[WIDTH];
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] result,
  input  logic             a_msb,
  input  logic             b_eff_msb,
  input  logic             carry_out,
  output cond_flags_t      flags
);
  localparam int unsigned MSB = WIDTH - 1;

  always_comb begin
    flags.z = ~(|result);
    flags.n = result[MSB];
    flags.c = carry_out;
    flags.v = ~(a_msb ^ b_eff_msb) & (a_msb ^ result[MSB]);
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             sub_sel,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_c,
  output logic             flag_v
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] raw_sum;
  logic             carry_top;
  cond_flags_t      flg;

  addsub_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .raw_b  (opb),
    .invert (sub_sel),
    .eff_b  (b_eff)
  );

  addsub_ripple #(.WIDTH(WIDTH)) u_add (
    .in_a      (opa),
    .in_b      (b_eff),
    .carry_in  (cin),
    .result    (raw_sum),
    .carry_out (carry_top)
  );

  addsub_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .result    (raw_sum),
    .a_msb     (opa[MSB]),
    .b_eff_msb (b_eff[MSB]),
    .carry_out (carry_top),
    .flags     (flg)
  );

  assign sum    = raw_sum;
  assign flag_z = flg.z;
  assign flag_n = flg.n;
  assign flag_c = flg.c;
  assign flag_v = flg.v;
endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             sub_sel,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             flag_z,
  input logic             flag_n,
  input logic             flag_c,
  input logic             flag_v
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] mask;
  logic [WIDTH:0]   wide;
  logic             same_sign;

  always_comb begin
    mask      = {WIDTH{sub_sel}};
    wide      = {1'b0, opa} + {1'b0, opb ^ mask} + {{WIDTH{1'b0}}, cin};
    same_sign = (opa[MSB] == (opb[MSB] ^ sub_sel));
    AST_SUM_VALUE: assert ({flag_c, sum} == wide);                           // R1
    AST_CARRY_OUT: assert (flag_c == wide[WIDTH]);                           // R3
    AST_SIGN_BIT: assert (flag_n == sum[MSB]);                               // R4
    AST_ZERO_DETECT: assert (flag_z == (sum == '0));                         // R5
    AST_SIGNED_OVF: assert (flag_v == (same_sign && (sum[MSB] != opa[MSB]))); // R6
    if (sub_sel && cin) begin
      AST_NO_BORROW: assert (flag_c == (opa >= opb));                        // R7
    end
  end
endmodule

bind addsub_flags addsub_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .opa     (opa),
  .opb     (opb),
  .sub_sel (sub_sel),
  .cin     (cin),
  .sum     (sum),
  .flag_z  (flag_z),
  .flag_n  (flag_n),
  .flag_c  (flag_c),
  .flag_v  (flag_v)
);

// File: tb/addsub_flags_test.sv
module addsub_flags_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;
  localparam int  N_RANDOM   = 2000;

  logic       clk;
  logic       rst_n;
  logic [7:0] opa, opb, sum;
  logic       sub_sel, cin;
  logic       flag_z, flag_n, flag_c, flag_v;

  int checks;
  int errors;
  int cycles;
  bit done;

  addsub_flags uut (
    .opa     (opa),
    .opb     (opb),
    .sub_sel (sub_sel),
    .cin     (cin),
    .sum     (sum),
    .flag_z  (flag_z),
    .flag_n  (flag_n),
    .flag_c  (flag_c),
    .flag_v  (flag_v)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  function automatic logic [8:0] ref_wide(input logic [7:0] a, input logic [7:0] b,
                                          input logic s, input logic c);
    logic [7:0] eb;
    eb = s ? ~b : b;
    return {1'b0, a} + {1'b0, eb} + {8'd0, c};
  endfunction

  function automatic logic ref_ovf(input logic [7:0] a, input logic [7:0] b,
                                   input logic s, input logic c);
    int sa, sb, r;
    sa = int'($signed(a));
    sb = int'($signed(s ? ~b : b));
    r  = sa + sb + int'(c);
    return (r > 127) || (r < -128);
  endfunction

  // drive on rising edge, sample on falling edge
  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic s, input logic c);
    @(posedge clk);
    opa = a; opb = b; sub_sel = s; cin = c;
    @(negedge clk);
  endtask

  task automatic full_check(input logic [7:0] a, input logic [7:0] b, input logic s, input logic c);
    logic [8:0] w;
    apply(a, b, s, c);
    w = ref_wide(a, b, s, c);
    check(sum == w[7:0], s ? "R2 sum" : "R1 sum", sum, w[7:0]);
    check(flag_c == w[8], "R3 carry", flag_c, w[8]);
    check(flag_n == w[7], "R4 negative", flag_n, w[7]);
    check(flag_z == (w[7:0] == 8'd0), "R5 zero", flag_z, w[7:0] == 8'd0);
    check(flag_v == ref_ovf(a, b, s, c), "R6 overflow", flag_v, ref_ovf(a, b, s, c));
    if (s && c) check(flag_c == (a >= b), "R7 no-borrow", flag_c, a >= b);
  endtask

  task automatic chain16(input logic [15:0] x, input logic dec);
    logic [15:0] exp16;
    logic [7:0]  lo;
    logic        cy;
    exp16 = dec ? x - 16'd1 : x + 16'd1;
    apply(x[7:0], 8'd1, dec, dec);
    lo = sum; cy = flag_c;
    apply(x[15:8], 8'd0, dec, cy);
    check({sum, lo} == exp16, "R8 chain16", {sum, lo}, exp16);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (!done && cycles > WATCHDOG) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed0;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    opa = 8'd0; opb = 8'd0; sub_sel = 1'b0; cin = 1'b0;
    seed0 = $urandom(32'd20240611);
    // R9: outputs valid while reset is held and before any edge
    #1;
    check(sum == 8'd0 && flag_z && !flag_c && !flag_n && !flag_v, "R9 initial", {flag_z, sum}, 9'h100);
    opa = 8'h12; opb = 8'h34; #1;
    check(sum == 8'h46, "R9 no-clock", sum, 8'h46);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // directed corners
    full_check(8'h7F, 8'h01, 1'b0, 1'b0); // R6 positive overflow, R4
    check(flag_v == 1'b1 && flag_n == 1'b1, "R6 7F+1", {flag_v, flag_n}, 2'b11);
    full_check(8'h80, 8'h01, 1'b1, 1'b1); // R6 negative overflow via subtract
    check(sum == 8'h7F && flag_v, "R6 80-1", {flag_v, sum}, 9'h17F);
    full_check(8'hFF, 8'h01, 1'b0, 1'b0); // R3 carry, R5 zero
    check(flag_z && flag_c, "R5 FF+1", {flag_z, flag_c}, 2'b11);
    full_check(8'h00, 8'h00, 1'b1, 1'b1); // R7 no borrow on equal
    check(flag_z && flag_c && !flag_v, "R7 0-0", {flag_z, flag_c, flag_v}, 3'b110);
    full_check(8'h00, 8'h01, 1'b1, 1'b1); // R7 borrow
    check(!flag_c && sum == 8'hFF, "R7 0-1", {flag_c, sum}, 9'h0FF);
    full_check(8'h05, 8'h03, 1'b1, 1'b0); // R2 subtract without carry-in
    check(sum == 8'h01, "R2 5-3-1", sum, 8'h01);
    full_check(8'h05, 8'h03, 1'b0, 1'b1); // R1 add with carry-in
    check(sum == 8'h09, "R1 5+3+1", sum, 8'h09);

    // chained 16-bit
    chain16(16'h00FF, 1'b0);
    chain16(16'hFFFF, 1'b0);
    chain16(16'h1234, 1'b0);
    chain16(16'h0100, 1'b1);
    chain16(16'h0000, 1'b1);
    chain16(16'h8000, 1'b1);

    // random sweep over all mode/carry combinations
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      if ((i % 16) == 0) rb = ra;
      full_check(ra, rb, 1'(i % 2), 1'((i / 2) % 2));
    end
    for (int i = 0; i < 50; i++) begin
      logic [15:0] rx;
      rx = 16'($urandom);
      chain16(rx, 1'(i % 2));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule